// File: doc/BRIEF.md
# Packed Bucket Fetch and Search

This block serves one lookup at a time in a hashed forwarding table. It takes a lookup key and the index of the one bucket that may hold that key. It issues a single read request to external memory, then takes the bucket back as a stream of wide memory words. The routing entries are packed end to end with no alignment to word boundaries, so an entry can start in one word and finish in the next. The block rebuilds each entry as the words arrive and compares its prefix with the key. It keeps the first matching slot.

A small ternary-match table outside the block covers the prefix lengths that are not held in the hashed buckets. That table works in parallel with the hashed path, and its answer (hit flag, matched length and port) is presented together with the request. When the last word of the bucket has been taken in, the block merges the two answers under a fixed priority. It then issues one result after a fixed delay, whatever slot the hit was in and whether or not there was a hit. Since only one bucket is read for each key, every lookup costs the same number of cycles.

Top module: `bkt_fetch_search`

## Requirements
- R1: A slot is `ENTRY_W` = `KEY_W`+`PORT_W` bits wide. The prefix is in the upper `KEY_W` bits (bits 39:16 by default) and the output port is in the lower `PORT_W` bits (bits 15:0). A slot hits when its prefix equals `req_key` in every bit.
- R2: The bucket is a bit stream in which beat i supplies stream bits i*`BEAT_W` upward, and the beat's bit 0 is its lowest stream bit. Slot j occupies stream bits j*`ENTRY_W` to j*`ENTRY_W`+`ENTRY_W`-1, so a slot may span two beats. A bucket takes ceil(`ENTRY_W`*`SLOTS`/`BEAT_W`) beats, which is 3 by default.
- R3: For each accepted request, `mem_req_valid` is high for exactly one cycle: the cycle after the request is accepted. In that cycle `mem_req_addr` = `req_bucket` * beats per bucket.
- R4: A slot whose bits are all zero is empty and never hits, even when `req_key` is zero. A slot with a zero prefix and a nonzero port is not empty.
- R5: When more than one slot hits, the port reported is the one from the lowest-numbered slot.
- R6: Stream bits above the last slot (padding in the final beat) never produce a hit.
- R7: Result priority, highest first: a ternary hit of length 25..32, then a bucket hit, then a ternary hit of length 8..18. `res_src` encodes these as 1, 2 and 3, and 0 means a miss.
- R8: `tern_len` and `tern_port` are sampled with the request. A ternary hit whose length lies outside 8..18 and 25..32 (for example 19..24) is treated as no ternary hit, and so is any input with `tern_hit` low.
- R9: `res_valid` is high for exactly one cycle: the second cycle after the cycle in which the last beat is presented on `rd_valid`. This holds whatever the position of the hit and whatever the gaps between beats.
- R10: `req_ready` is high only while no lookup is in progress. It drops the cycle after acceptance and returns in the cycle `res_valid` is high. `rd_valid` is ignored while no fetch is in progress.
- R11: After reset, `req_ready` is 1 and both `res_valid` and `mem_req_valid` are 0.
- R12: On a miss, `res_hit` is 0, `res_port` is 0 and `res_src` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_key | input | KEY_W | Lookup key (prefix already extracted) |
| req_bucket | input | BID_W | Bucket index to fetch |
| tern_hit | input | 1 | Ternary table reports a hit |
| tern_len | input | LEN_W | Prefix length of the ternary hit |
| tern_port | input | PORT_W | Port from the ternary hit |
| mem_req_valid | output | 1 | Bucket read request |
| mem_req_addr | output | ADDR_W | First word address of the bucket |
| rd_valid | input | 1 | Read-data beat present |
| rd_data | input | BEAT_W | Read-data beat |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | Some source hit |
| res_port | output | PORT_W | Selected output port |
| res_src | output | 2 | 0 miss, 1 long ternary, 2 bucket, 3 short ternary |

## Verification
The bench places matching entries in the slots that span beat boundaries (slots 1 and 3). If the unpacker dropped or misaligned the carried bits, those lookups would miss or return another port. It also fills the padding of the last beat with a perfect match for the key, to catch a design that searches past the last slot. It sets up buckets holding duplicate matches, all-zero slots and a zero-prefix slot, which catches a design that reports the last match or treats zero slots as valid. Ternary inputs at lengths 8, 18, 19, 20, 25, 28 and 32 test the priority and the range edges. Gaps between beats and stray `rd_valid` pulses while idle test that the result time is counted from the last beat and not from any other event.

// File: rtl/bkt_srch_pkg.sv
package bkt_srch_pkg;

  typedef enum logic [1:0] {
    SRC_NONE       = 2'd0,
    SRC_TERN_LONG  = 2'd1,
    SRC_BUCKET     = 2'd2,
    SRC_TERN_SHORT = 2'd3
  } res_src_e;

  typedef enum logic [1:0] {
    TCLS_NONE  = 2'd0,
    TCLS_LONG  = 2'd1,
    TCLS_SHORT = 2'd2
  } tern_cls_e;

  // Rounded-up division used for beats per bucket.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Most whole entries that can complete inside one beat plus carried bits.
  function automatic int lanes_per_beat(input int entry_w, input int beat_w);
    return (beat_w + entry_w - 1) / entry_w;
  endfunction

  // Classify a ternary answer by matched length.
  function automatic tern_cls_e tern_class(input logic hit, input int len);
    if (!hit)                      return TCLS_NONE;
    if (len >= 25 && len <= 32)    return TCLS_LONG;
    if (len >= 8 && len <= 18)     return TCLS_SHORT;
    return TCLS_NONE;
  endfunction

endpackage

// File: rtl/bkt_unpack.sv
module bkt_unpack #(
  parameter int ENTRY_W = 40,
  parameter int BEAT_W  = 72,
  parameter int SLOTS   = 4,
  parameter int LANES   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic                            beat_valid,
  input  logic [BEAT_W-1:0]               beat_data,
  output logic [LANES-1:0][ENTRY_W-1:0]   lane_entry,
  output logic [LANES-1:0]                lane_ok
);
  localparam int WIN_W = BEAT_W + ENTRY_W - 1;
  localparam int CW    = ENTRY_W - 1;
  localparam int CLW   = $clog2(ENTRY_W);
  localparam int SW    = $clog2(SLOTS + 1);

  logic [CW-1:0]    carry_q;
  logic [CLW-1:0]   clen_q;
  logic [SW-1:0]    base_q;
  logic [WIN_W-1:0] window;
  logic [WIN_W-1:0] shifted;
  int               avail;
  int               taken;
  logic             slots_done;

  always_comb begin
    window = (WIN_W'(beat_data) << clen_q) | WIN_W'(carry_q);
    avail  = int'(clen_q) + BEAT_W;
    taken  = 0;
    for (int j = 0; j < LANES; j++) begin
      lane_entry[j] = window[j*ENTRY_W +: ENTRY_W];
      lane_ok[j]    = beat_valid && (((j + 1) * ENTRY_W) <= avail) &&
                      ((int'(base_q) + j) < SLOTS);
      if (lane_ok[j]) taken = taken + 1;
    end
    shifted    = window >> (taken * ENTRY_W);
    slots_done = (int'(base_q) + taken) >= SLOTS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      carry_q <= '0;
      clen_q  <= '0;
      base_q  <= '0;
    end else if (beat_valid) begin
      base_q <= base_q + SW'(taken);
      if (slots_done) begin
        carry_q <= '0;
        clen_q  <= '0;
      end else begin
        carry_q <= shifted[CW-1:0];
        clen_q  <= CLW'(avail - taken * ENTRY_W);
      end
    end
  end

  // R2: carried bits never reach a whole entry
  p_carry_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(clen_q) < ENTRY_W);

  // R2: every beat that arrives while slots remain yields at least one entry
  p_progress_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && (int'(base_q) < SLOTS)) |-> lane_ok[0]);

  // R6: no slot is produced past the bucket capacity
  p_capacity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(base_q) <= SLOTS);

  generate
    for (genvar g = 1; g < LANES; g++) begin : g_order
      // R2: lanes fill in stream order
      p_lane_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lane_ok[g] |-> lane_ok[g-1]);
    end
  endgenerate

endmodule

// File: rtl/bkt_match.sv
module bkt_match #(
  parameter int KEY_W  = 24,
  parameter int PORT_W = 16,
  parameter int LANES  = 2
) (
  input  logic [LANES-1:0][KEY_W+PORT_W-1:0] lane_entry,
  input  logic [LANES-1:0]                   lane_ok,
  input  logic [KEY_W-1:0]                   key,
  output logic                               any_hit,
  output logic [PORT_W-1:0]                  hit_port
);
  localparam int ENTRY_W = KEY_W + PORT_W;

  logic [LANES-1:0] lane_hit;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
      assign lane_hit[g] = lane_ok[g] && (lane_entry[g] != '0) &&
                           (lane_entry[g][ENTRY_W-1 -: KEY_W] == key);
    end
  endgenerate

  always_comb begin
    any_hit  = 1'b0;
    hit_port = '0;
    for (int j = LANES - 1; j >= 0; j--) begin
      if (lane_hit[j]) begin
        any_hit  = 1'b1;
        hit_port = lane_entry[j][PORT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/bkt_merge.sv
module bkt_merge
  import bkt_srch_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int LEN_W  = 6
) (
  input  logic              tern_hit,
  input  logic [LEN_W-1:0]  tern_len,
  input  logic [PORT_W-1:0] tern_port,
  input  logic              bkt_hit,
  input  logic [PORT_W-1:0] bkt_port,
  output logic              hit,
  output logic [PORT_W-1:0] port,
  output res_src_e          src
);
  tern_cls_e cls;

  always_comb begin
    cls  = tern_class(tern_hit, int'(tern_len));
    hit  = 1'b1;
    port = '0;
    src  = SRC_NONE;
    if (cls == TCLS_LONG) begin
      port = tern_port;
      src  = SRC_TERN_LONG;
    end else if (bkt_hit) begin
      port = bkt_port;
      src  = SRC_BUCKET;
    end else if (cls == TCLS_SHORT) begin
      port = tern_port;
      src  = SRC_TERN_SHORT;
    end else begin
      hit  = 1'b0;
    end
  end

endmodule

// File: rtl/bkt_fetch_search.sv
module bkt_fetch_search
  import bkt_srch_pkg::*;
#(
  parameter int KEY_W  = 24,
  parameter int PORT_W = 16,
  parameter int BEAT_W = 72,
  parameter int SLOTS  = 4,
  parameter int BID_W  = 12,
  parameter int LEN_W  = 6,
  localparam int ENTRY_W = KEY_W + PORT_W,
  localparam int BEATS   = ceil_div(ENTRY_W * SLOTS, BEAT_W),
  localparam int BCNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int ADDR_W  = BID_W + BCNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KEY_W-1:0]  req_key,
  input  logic [BID_W-1:0]  req_bucket,
  input  logic              tern_hit,
  input  logic [LEN_W-1:0]  tern_len,
  input  logic [PORT_W-1:0] tern_port,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              rd_valid,
  input  logic [BEAT_W-1:0] rd_data,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PORT_W-1:0] res_port,
  output logic [1:0]        res_src
);
  localparam int LANES = lanes_per_beat(ENTRY_W, BEAT_W);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MERGE} state_e;

  state_e                         state_q;
  logic [KEY_W-1:0]               key_q;
  logic                           th_q;
  logic [LEN_W-1:0]               tlen_q;
  logic [PORT_W-1:0]              tport_q;
  logic [BCNT_W-1:0]              beat_cnt_q;
  logic                           found_q;
  logic [PORT_W-1:0]              found_port_q;

  // Named internal events
  logic                           accept;
  logic                           beat_acc;
  logic                           last_beat;
  logic [LANES-1:0][ENTRY_W-1:0]  lane_entry;
  logic [LANES-1:0]               lane_ok;
  logic                           beat_hit;
  logic [PORT_W-1:0]              beat_port;
  logic                           mrg_hit;
  logic [PORT_W-1:0]              mrg_port;
  res_src_e                       mrg_src;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign beat_acc  = rd_valid && (state_q == ST_FETCH);
  assign last_beat = beat_acc && (int'(beat_cnt_q) == BEATS - 1);

  bkt_unpack #(
    .ENTRY_W (ENTRY_W),
    .BEAT_W  (BEAT_W),
    .SLOTS   (SLOTS),
    .LANES   (LANES)
  ) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .beat_valid (beat_acc),
    .beat_data  (rd_data),
    .lane_entry (lane_entry),
    .lane_ok    (lane_ok)
  );

  bkt_match #(
    .KEY_W  (KEY_W),
    .PORT_W (PORT_W),
    .LANES  (LANES)
  ) u_match (
    .lane_entry (lane_entry),
    .lane_ok    (lane_ok),
    .key        (key_q),
    .any_hit    (beat_hit),
    .hit_port   (beat_port)
  );

  bkt_merge #(
    .PORT_W (PORT_W),
    .LEN_W  (LEN_W)
  ) u_merge (
    .tern_hit  (th_q),
    .tern_len  (tlen_q),
    .tern_port (tport_q),
    .bkt_hit   (found_q),
    .bkt_port  (found_port_q),
    .hit       (mrg_hit),
    .port      (mrg_port),
    .src       (mrg_src)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      key_q         <= '0;
      th_q          <= 1'b0;
      tlen_q        <= '0;
      tport_q       <= '0;
      beat_cnt_q    <= '0;
      found_q       <= 1'b0;
      found_port_q  <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      res_valid     <= 1'b0;
      res_hit       <= 1'b0;
      res_port      <= '0;
      res_src       <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      res_valid     <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            key_q         <= req_key;
            th_q          <= tern_hit;
            tlen_q        <= tern_len;
            tport_q       <= tern_port;
            beat_cnt_q    <= '0;
            found_q       <= 1'b0;
            found_port_q  <= '0;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= ADDR_W'(req_bucket) * ADDR_W'(BEATS);
            state_q       <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (beat_acc) begin
            beat_cnt_q <= beat_cnt_q + 1'b1;
            if (!found_q && beat_hit) begin
              found_q      <= 1'b1;
              found_port_q <= beat_port;
            end
            if (last_beat) state_q <= ST_MERGE;
          end
        end
        ST_MERGE: begin
          res_valid <= 1'b1;
          res_hit   <= mrg_hit;
          res_port  <= mrg_port;
          res_src   <= mrg_src;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: one read request, in the cycle after acceptance
  p_req_follows_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_req_valid);
  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R9: result exactly two cycles after the last beat, one cycle wide
  p_fixed_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> ##1 res_valid);
  p_res_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R10: no new request while a lookup is in flight
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R12: a miss carries a zero port and source
  p_miss_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_port == '0 && res_src == 2'd0));

endmodule

// File: tb/bkt_fetch_search_tb.sv
module bkt_fetch_search_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;
  localparam int BEATS = 3;
  localparam int SW    = BEATS * 72;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_key = '0;
  logic [11:0] req_bucket = '0;
  logic        tern_hit = 1'b0;
  logic [5:0]  tern_len = '0;
  logic [15:0] tern_port = '0;
  logic        mem_req_valid;
  logic [13:0] mem_req_addr;
  logic        rd_valid = 1'b0;
  logic [71:0] rd_data = '0;
  logic        res_valid;
  logic        res_hit;
  logic [15:0] res_port;
  logic [1:0]  res_src;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [71:0] mem [int];
  logic [39:0] bk [16][SLOTS];

  always #(CLK_PERIOD/2) clk = ~clk;

  bkt_fetch_search dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_key(req_key), .req_bucket(req_bucket),
    .tern_hit(tern_hit), .tern_len(tern_len), .tern_port(tern_port),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .res_valid(res_valid), .res_hit(res_hit),
    .res_port(res_port), .res_src(res_src)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] ent(input logic [23:0] p, input logic [15:0] port);
    return {p, port};
  endfunction

  // Lay the slots end to end as one bit stream and cut it into words.
  task automatic load_bucket(input int b, input logic [39:0] e0, input logic [39:0] e1,
                             input logic [39:0] e2, input logic [39:0] e3,
                             input logic [55:0] pad);
    logic [SW-1:0] s;
    bk[b][0] = e0; bk[b][1] = e1; bk[b][2] = e2; bk[b][3] = e3;
    s = '0;
    for (int j = 0; j < SLOTS; j++) s[j*40 +: 40] = bk[b][j];
    s[SLOTS*40 +: 56] = pad;
    for (int i = 0; i < BEATS; i++) mem[b*BEATS + i] = s[i*72 +: 72];
  endtask

  // Behavioural expectation from the requirement text.
  task automatic expect_of(input int b, input logic [23:0] key, input bit th,
                           input int tlen, input logic [15:0] tport,
                           output bit eh, output logic [15:0] ep, output int es);
    bit bh = 1'b0;
    logic [15:0] bp = '0;
    for (int j = SLOTS - 1; j >= 0; j--)
      if (bk[b][j] != '0 && bk[b][j][39:16] == key) begin bh = 1'b1; bp = bk[b][j][15:0]; end
    eh = 1'b1;
    if (th && tlen >= 25 && tlen <= 32) begin ep = tport; es = 1; end
    else if (bh) begin ep = bp; es = 2; end
    else if (th && tlen >= 8 && tlen <= 18) begin ep = tport; es = 3; end
    else begin eh = 1'b0; ep = '0; es = 0; end
  endtask

  task automatic lookup(input string tag, input int b, input logic [23:0] key,
                        input bit th, input int tlen, input logic [15:0] tport,
                        input int gap);
    bit eh; logic [15:0] ep; int es;
    expect_of(b, key, th, tlen, tport, eh, ep, es);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", {tag, " ready idle"}, req_ready, 1);
    req_valid = 1'b1; req_key = key; req_bucket = 12'(b);
    tern_hit = th; tern_len = 6'(tlen); tern_port = tport;
    @(negedge clk);
    req_valid = 1'b0; tern_hit = 1'b0; tern_port = 16'hDEAD; tern_len = 6'd28;
    chk(mem_req_valid == 1'b1, "R3", {tag, " read req"}, mem_req_valid, 1);
    chk(mem_req_addr == 14'(b * BEATS), "R3", {tag, " read addr"}, mem_req_addr, b * BEATS);
    chk(req_ready == 1'b0, "R10", {tag, " busy"}, req_ready, 0);
    for (int i = 0; i < BEATS; i++) begin
      for (int g = 0; g < gap; g++) begin
        rd_valid = 1'b0;
        @(negedge clk);
        chk(res_valid == 1'b0, "R9", {tag, " early result"}, res_valid, 0);
      end
      rd_valid = 1'b1; rd_data = mem[b*BEATS + i];
      @(negedge clk);
      chk(mem_req_valid == 1'b0, "R3", {tag, " single req"}, mem_req_valid, 0);
    end
    rd_valid = 1'b0; rd_data = '1;
    chk(res_valid == 1'b0, "R9", {tag, " not yet"}, res_valid, 0);
    @(negedge clk);
    chk(res_valid == 1'b1, "R9", {tag, " result time"}, res_valid, 1);
    chk(res_hit == eh, tag, "hit", res_hit, eh);
    chk(res_port == ep, tag, "port", res_port, ep);
    chk(int'(res_src) == es, tag, "src", res_src, es);
    chk(req_ready == 1'b1, "R10", {tag, " ready back"}, req_ready, 1);
    @(negedge clk);
    chk(res_valid == 1'b0, "R9", {tag, " one cycle"}, res_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    load_bucket(1, ent(24'hA0A0A0, 16'h1111), ent(24'hB1B1B1, 16'h2222), 40'h0,
                ent(24'hC3C3C3, 16'h4444), 56'h0);
    load_bucket(2, ent(24'h123456, 16'h0F0F), ent(24'hE5E5E5, 16'h5501),
                ent(24'hE5E5E5, 16'h5502), ent(24'hE5E5E5, 16'h5503), 56'h0);
    load_bucket(3, 40'h0, 40'h0, 40'h0, 40'h0, {16'h0, 24'hF6F6F6, 16'h7777});
    load_bucket(15, ent(24'h000000, 16'h0009), 40'h0, 40'h0, 40'h0, 56'h0);

    repeat (3) @(negedge clk);
    // R11: reset values
    chk(req_ready == 1'b1, "R11", "ready", req_ready, 1);
    chk(res_valid == 1'b0, "R11", "res_valid", res_valid, 0);
    chk(mem_req_valid == 1'b0, "R11", "mem_req_valid", mem_req_valid, 0);
    rst_n = 1'b1;

    lookup("R1 slot0", 1, 24'hA0A0A0, 0, 0, 16'h0, 0);
    lookup("R2 slot1 spans beats", 1, 24'hB1B1B1, 0, 0, 16'h0, 1);
    lookup("R2 slot3 spans beats", 1, 24'hC3C3C3, 0, 0, 16'h0, 2);
    lookup("R12 miss", 1, 24'hD4D4D4, 0, 0, 16'h0, 0);
    lookup("R5 lowest slot", 2, 24'hE5E5E5, 0, 0, 16'h0, 1);
    lookup("R4 empty slots", 3, 24'h000000, 0, 0, 16'h0, 0);
    lookup("R6 padding bait", 3, 24'hF6F6F6, 0, 0, 16'h0, 0);
    lookup("R4 zero prefix", 15, 24'h000000, 0, 0, 16'h0, 0);
    lookup("R7 long over bucket", 1, 24'hA0A0A0, 1, 28, 16'hAAAA, 0);
    lookup("R7 bucket over short", 1, 24'hA0A0A0, 1, 12, 16'hAAAA, 1);
    lookup("R8 short len 8", 1, 24'hD4D4D4, 1, 8, 16'hBBBB, 0);
    lookup("R8 short len 18", 1, 24'hD4D4D4, 1, 18, 16'hBBBC, 0);
    lookup("R8 len 20 ignored", 1, 24'hD4D4D4, 1, 20, 16'hBBBD, 0);
    lookup("R8 len 19 ignored", 1, 24'hA0A0A0, 1, 19, 16'hBBBE, 0);
    lookup("R8 long len 25", 1, 24'hD4D4D4, 1, 25, 16'hCCC1, 1);
    lookup("R8 long len 32", 2, 24'hE5E5E5, 1, 32, 16'hCCC2, 0);
    lookup("R8 no hit flag", 1, 24'hD4D4D4, 0, 28, 16'hCCC3, 0);

    // R10: stray read data while idle is ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd_valid = 1'b1; rd_data = mem[1*BEATS];
      chk(res_valid == 1'b0, "R10", "stray beat result", res_valid, 0);
      chk(req_ready == 1'b1, "R10", "stray beat ready", req_ready, 1);
    end
    @(negedge clk);
    rd_valid = 1'b0;
    chk(res_valid == 1'b0, "R10", "stray beat result", res_valid, 0);
    lookup("R10 after stray", 2, 24'h123456, 0, 0, 16'h0, 0);
    lookup("R3 high bucket", 15, 24'h777777, 0, 0, 16'h0, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule